// File: doc/BRIEF.md
# Sized Doorbell Write Generator

When a request finishes, this block may post one memory write to a doorbell location. The write is 8, 16 or 32 bits wide and goes to a 64-bit byte address. An attribute byte controls the write. Its top bit turns the write on or off, and its low two bits choose the width. The block moves the low bits of a 32-bit payload into the correct byte lane of a 32-bit write bus and sets the matching byte enables. It refuses any write whose address is not a multiple of the chosen width.

A caller places the address, attribute and payload on the inputs and raises `start_i` for one cycle. The block then does one of three things:

- It posts a single write on a valid/ready channel and pulses `done_o` after the handshake.
- It pulses `done_o` alone when the write is disabled.
- It pulses `done_o` together with `err_o` when the request is illegal.

While a write waits for `wr_ready_i`, the block ignores any new start.

Top module: `doorbell_writer`

## Requirements
- R1: During and right after reset, `wr_valid_o`, `done_o` and `err_o` are low.
- R2: A start with attribute bit 7 clear issues no write. `done_o` is high for one cycle, in the cycle after the start edge, and `err_o` stays low. The width code is not examined in this case, so code 3 raises no error.
- R3: Width code 0 (attribute bits 1:0 = 0) with address bits 1:0 = 0 posts a write in the cycle after the start edge. The write carries the given address, the whole data word and byte enables 4'b1111.
- R4: Width code 1 (16-bit) with address bit 0 clear posts a write. The data low 16 bits are placed at bit 16*addr[1], the byte enables are 4'b0011 shifted left by 2*addr[1], and every other data bit is zero.
- R5: Width code 2 (8-bit) posts a write with the data low 8 bits placed at bit 8*addr[1:0]. The byte enables are a single bit at position addr[1:0], and every other data bit is zero.
- R6: An enabled request whose address is not a multiple of the width issues no write. The address is misaligned when addr[1:0] is nonzero for 32-bit, or when addr[0] is set for 16-bit. `done_o` and `err_o` are then both high for one cycle, in the cycle after the start edge.
- R7: An enabled request with width code 3 issues no write. `done_o` and `err_o` are both high for one cycle, in the cycle after the start edge.
- R8: Attribute bits 6:2 have no effect on the outcome.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, the write stays pending and the address, data and byte enables hold steady.
- R10: After the edge where `wr_valid_o` and `wr_ready_i` are both high, `wr_valid_o` falls. `done_o` is high for exactly the next cycle, and `err_o` stays low.
- R11: A start that arrives while a write is pending is ignored. The pending write keeps its fields, and the ignored start produces no extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| db_addr_i | input | 64 | Doorbell byte address |
| db_attr_i | input | 8 | Attribute byte (bit 7 enable, bits 1:0 width) |
| db_data_i | input | 32 | Payload word |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | 64 | Write byte address |
| wr_data_o | output | 32 | Lane-placed write data |
| wr_be_o | output | 4 | Byte enables |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Rejected-request pulse |

## Verification
Each request outcome is due a fixed number of cycles after its trigger:

- A posted write appears on the bus in the cycle after the start edge.
- A disabled or rejected request shows `done_o` (and `err_o` for a rejected one) in the cycle after the start edge.
- A completed write shows `done_o` in the cycle after the handshake edge.

The bench drives every input on the falling edge and samples on the following falling edge, so each check lands exactly in the cycle where the result is due. It samples again one cycle later to confirm that the pulses have dropped. While a write waits under random back-pressure, the bench checks the held fields every cycle and injects stray starts to confirm that they change nothing.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  localparam int ADDR_W = 64;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int LANE_W = $clog2(BE_W);

  typedef enum logic [1:0] {
    WID_32  = 2'd0,
    WID_16  = 2'd1,
    WID_8   = 2'd2,
    WID_BAD = 2'd3
  } wid_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_POST = 1'b1
  } st_e;

  // number of bytes moved for a width code (0 for the reserved code)
  function automatic logic [2:0] wid_bytes(input wid_e w);
    case (w)
      WID_32:  return 3'd4;
      WID_16:  return 3'd2;
      WID_8:   return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // natural alignment test on the low address bits
  function automatic logic wid_aligned(input wid_e w, input logic [LANE_W-1:0] lo);
    case (w)
      WID_32:  return (lo == '0);
      WID_16:  return (lo[0] == 1'b0);
      WID_8:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // byte-enable pattern positioned at the addressed lane
  function automatic logic [BE_W-1:0] wid_be(input wid_e w, input logic [LANE_W-1:0] lo);
    logic [BE_W-1:0] base;
    case (w)
      WID_32:  base = '1;
      WID_16:  base = {{(BE_W-2){1'b0}}, 2'b11};
      WID_8:   base = {{(BE_W-1){1'b0}}, 1'b1};
      default: base = '0;
    endcase
    return (w == WID_32) ? base : (base << lo);
  endfunction

  // payload trimmed to the width and moved onto its byte lane
  function automatic logic [DATA_W-1:0] wid_data(input wid_e w, input logic [LANE_W-1:0] lo,
                                                 input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] trimmed;
    case (w)
      WID_32:  trimmed = d;
      WID_16:  trimmed = {{(DATA_W-16){1'b0}}, d[15:0]};
      WID_8:   trimmed = {{(DATA_W-8){1'b0}}, d[7:0]};
      default: trimmed = '0;
    endcase
    return (w == WID_32) ? trimmed : (trimmed << {lo, 3'b000});
  endfunction

endpackage

// File: rtl/doorbell_attr_decode.sv
module doorbell_attr_decode
  import doorbell_pkg::*;
(
  input  logic [7:0] attr_i,
  output logic       en_o,
  output wid_e       wid_o,
  output logic       wid_legal_o
);
  logic [4:0] unused_rsvd;

  assign en_o        = attr_i[7];
  assign wid_o       = wid_e'(attr_i[1:0]);
  assign wid_legal_o = (wid_bytes(wid_e'(attr_i[1:0])) != 3'd0);
  assign unused_rsvd = attr_i[6:2];
endmodule

// File: rtl/doorbell_lane_pack.sv
module doorbell_lane_pack
  import doorbell_pkg::*;
(
  input  wid_e               wid_i,
  input  logic [LANE_W-1:0]  lo_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               aligned_o,
  output logic [BE_W-1:0]    be_o,
  output logic [DATA_W-1:0]  data_o
);
  assign aligned_o = wid_aligned(wid_i, lo_i);
  assign be_o      = wid_be(wid_i, lo_i);
  assign data_o    = wid_data(wid_i, lo_i, data_i);
endmodule

// File: rtl/doorbell_writer.sv
module doorbell_writer
  import doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [63:0]       db_addr_i,
  input  logic [7:0]        db_attr_i,
  input  logic [31:0]       db_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [63:0]       wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o,
  output logic              done_o,
  output logic              err_o
);

  st_e               state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic              done_q, err_q;

  logic              dec_en, dec_legal, pk_aligned;
  wid_e              dec_wid;
  logic [BE_W-1:0]   pk_be;
  logic [DATA_W-1:0] pk_data;

  doorbell_attr_decode u_dec (
    .attr_i      (db_attr_i),
    .en_o        (dec_en),
    .wid_o       (dec_wid),
    .wid_legal_o (dec_legal)
  );

  doorbell_lane_pack u_pack (
    .wid_i     (dec_wid),
    .lo_i      (db_addr_i[LANE_W-1:0]),
    .data_i    (db_data_i),
    .aligned_o (pk_aligned),
    .be_o      (pk_be),
    .data_o    (pk_data)
  );

  // named events, used by the logic and by the assertions
  logic start_take, ev_skip, ev_fault, ev_issue, ev_hs;
  assign start_take = start_i && (state_q == ST_IDLE);
  assign ev_skip    = start_take && !dec_en;
  assign ev_fault   = start_take && dec_en && !(dec_legal && pk_aligned);
  assign ev_issue   = start_take && dec_en && dec_legal && pk_aligned;
  assign ev_hs      = (state_q == ST_POST) && wr_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= ev_skip || ev_fault || ev_hs;
      err_q  <= ev_fault;
      if (ev_issue) begin
        state_q <= ST_POST;
        addr_q  <= db_addr_i;
        data_q  <= pk_data;
        be_q    <= pk_be;
      end else if (ev_hs) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign wr_valid_o = (state_q == ST_POST);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign wr_be_o    = be_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R9: pending write holds its fields under back-pressure
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_be_o));

  // R10: handshake ends the write and completes next cycle without error
  a_r10_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i |=> !wr_valid_o && done_o && !err_o);

  // R2: disabled request completes quietly
  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> done_o && !err_o && !wr_valid_o);

  // R6 / R7: rejected request raises error with completion and no write
  a_r6_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> done_o && err_o && !wr_valid_o);

  // R6: an error never appears without completion
  a_r6_err_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R3 / R6: posted byte enables match a legal naturally aligned shape
  a_r3_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ((wr_be_o == 4'b1111) && (wr_addr_o[1:0] == 2'b00)) ||
                   ((($countones(wr_be_o) == 2) && (wr_be_o == 4'b0011 || wr_be_o == 4'b1100)) && !wr_addr_o[0]) ||
                   ($onehot0(wr_be_o) && (wr_be_o != 4'b0000)));

  // R11: a start while pending leaves the write pending
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && wr_valid_o && !wr_ready_i |=> wr_valid_o && !done_o);

endmodule

// File: tb/doorbell_writer_tb_top.sv
module doorbell_writer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] db_addr_i = '0;
  logic [7:0]  db_attr_i = '0;
  logic [31:0] db_data_i = '0;
  logic        wr_ready_i = 1'b0;
  logic        wr_valid_o, done_o, err_o;
  logic [63:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic [3:0]  wr_be_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  doorbell_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .db_addr_i(db_addr_i), .db_attr_i(db_attr_i), .db_data_i(db_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] code);
    return (code == 2'd0) ? 4 : (code == 2'd1) ? 2 : (code == 2'd2) ? 1 : 0;
  endfunction

  function automatic logic [3:0] model_be(input logic [1:0] code, input logic [1:0] off);
    int n = nbytes(code);
    logic [7:0] m = 8'((1 << n) - 1);
    m = m << off;
    return m[3:0];
  endfunction

  function automatic logic [31:0] model_data(input logic [1:0] code, input logic [1:0] off,
                                             input logic [31:0] d);
    int n = nbytes(code);
    logic [63:0] keep = (64'd1 << (8 * n)) - 64'd1;
    logic [63:0] v = ({32'd0, d} & keep) << (8 * off);
    return v[31:0];
  endfunction

  task automatic do_req(input logic [63:0] a, input logic [7:0] at, input logic [31:0] d,
                        input int delay, input bit inject);
    logic [1:0]  code = at[1:0];
    int          n = nbytes(code);
    bit          aligned_ok = (n != 0) && ((a % n) == 0);
    string       tag;
    logic [3:0]  ebe;
    logic [31:0] edata;
    if (at[6:2] != 5'd0) tag = "R8";
    else if (!at[7]) tag = "R2";
    else if (code == 2'd3) tag = "R7";
    else if (!aligned_ok) tag = "R6";
    else if (code == 2'd0) tag = "R3";
    else if (code == 2'd1) tag = "R4";
    else tag = "R5";
    @(negedge clk);
    start_i = 1'b1; db_addr_i = a; db_attr_i = at; db_data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    if (!at[7] || !aligned_ok) begin
      check(wr_valid_o == 1'b0, tag, "no write", {63'd0, wr_valid_o}, 64'd0);
      check(done_o == 1'b1, tag, "done pulse", {63'd0, done_o}, 64'd1);
      check(err_o == at[7], tag, "err flag", {63'd0, err_o}, {63'd0, at[7]});
      @(negedge clk);
      check(done_o == 1'b0 && err_o == 1'b0, tag, "pulse width", {62'd0, done_o, err_o}, 64'd0);
    end else begin
      ebe = model_be(code, a[1:0]);
      edata = model_data(code, a[1:0], d);
      check(wr_valid_o == 1'b1, tag, "valid", {63'd0, wr_valid_o}, 64'd1);
      check(wr_addr_o == a, tag, "addr", wr_addr_o, a);
      check(wr_data_o == edata, tag, "data", {32'd0, wr_data_o}, {32'd0, edata});
      check(wr_be_o == ebe, tag, "be", {60'd0, wr_be_o}, {60'd0, ebe});
      check(done_o == 1'b0, tag, "no early done", {63'd0, done_o}, 64'd0);
      for (int i = 0; i < delay; i++) begin
        if (inject && i == 0) begin
          start_i = 1'b1;
          db_addr_i = {$urandom, $urandom};
          db_attr_i = 8'h80 | 8'($urandom % 3);
          db_data_i = $urandom;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(wr_valid_o && wr_addr_o == a && wr_data_o == edata && wr_be_o == ebe,
              (inject && i == 0) ? "R11" : "R9", "held write",
              {28'd0, wr_be_o, wr_data_o}, {28'd0, ebe, edata});
        check(done_o == 1'b0, (inject && i == 0) ? "R11" : "R9", "no done while pending",
              {63'd0, done_o}, 64'd0);
      end
      wr_ready_i = 1'b1;
      @(negedge clk);
      wr_ready_i = 1'b0;
      check(wr_valid_o == 1'b0, "R10", "valid drops", {63'd0, wr_valid_o}, 64'd0);
      check(done_o == 1'b1 && err_o == 1'b0, "R10", "done after handshake",
            {62'd0, done_o, err_o}, 64'd2);
      @(negedge clk);
      check(done_o == 1'b0, "R10", "done one cycle", {63'd0, done_o}, 64'd0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0DB3_11A5));
    repeat (3) @(negedge clk);
    check(!wr_valid_o && !done_o && !err_o, "R1", "reset outputs",
          {61'd0, wr_valid_o, done_o, err_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_valid_o && !done_o && !err_o, "R1", "after reset",
          {61'd0, wr_valid_o, done_o, err_o}, 64'd0);

    do_req(64'h0000_1000_0000_0010, 8'h00, 32'hDEAD_BEEF, 0, 0); // R2 disabled
    do_req(64'h0000_1000_0000_0011, 8'h03, 32'h1, 0, 0);         // R2 disabled, code 3
    do_req(64'hFFFF_0000_1234_5678, 8'h80, 32'hCAFE_F00D, 0, 0); // R3
    do_req(64'h0000_0000_0000_0002, 8'h81, 32'hAAAA_5A5B, 2, 0); // R4 upper half
    do_req(64'h0000_0000_0000_0004, 8'h81, 32'h1234_8765, 0, 0); // R4 lower half
    do_req(64'h0000_0000_0000_0003, 8'h82, 32'hFFFF_FFC3, 1, 0); // R5 top lane
    do_req(64'h0000_0000_0000_0001, 8'h82, 32'h0000_0077, 0, 0); // R5 lane 1
    do_req(64'h0000_0000_0000_0001, 8'h81, 32'h0, 0, 0);         // R6 misaligned 16
    do_req(64'h0000_0000_0000_0002, 8'h80, 32'h0, 0, 0);         // R6 misaligned 32
    do_req(64'h0000_0000_0000_0000, 8'h83, 32'h0, 0, 0);         // R7 reserved code
    do_req(64'h0000_0000_0000_0006, 8'hFD, 32'h0000_BEEF, 1, 0); // R8 reserved bits, 16-bit
    do_req(64'h0000_0000_0000_0003, 8'h7E, 32'h0, 0, 0);         // R8 reserved bits, disabled
    do_req(64'h0000_0000_0000_0008, 8'h80, 32'h5555_AAAA, 3, 1); // R11 start while busy

    for (int k = 0; k < 400; k++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [7:0]  at = 8'($urandom);
      if (($urandom % 4) != 0) at[7] = 1'b1;
      if (($urandom % 3) != 0) at[6:2] = 5'd0;
      if (($urandom % 2) != 0) a[1:0] = 2'b00;
      do_req(a, at, $urandom, int'($urandom % 4), bit'($urandom % 2));
    end

    finish_run();
  end

endmodule